// File: doc/BRIEF.md
# Accelerator Kernel Launch Sequencer

This block is the control point through which an embedded processor hands a kernel to a reconfigurable array and gets it back. The processor programs a small set of word-wide registers over a simple register bus: where the kernel's configuration contexts start, how many there are, the source and destination data pointers and a load timeout. It then writes a start command. From that point the sequencer owns the job. It asks the configuration loader to fetch the contexts. Once the loader acknowledges, it lets the array run. When the array reports the end of the kernel, it asks for the results to be written back to shared memory. Only after that write-back is acknowledged does it raise a level interrupt.

The processor and the array never work at the same time. While a job is in flight the block reports busy and ignores register writes, so the job cannot be disturbed. The interrupt is only raised once the block is idle again. A status register reports progress and sticky error causes. A cycle register holds the length of the last kernel run, for performance measurement.

Top module: `acc_host_ctrl`

## Requirements
- R1: After reset the sequencer is idle: busy, done, irq, cfg_req, arr_run and wb_req are low, and every readable register returns 0.
- R2: Register map (3-bit word address): 0 control (bit 0 = start, reads 0), 1 context base, 2 context count, 3 source pointer, 4 destination pointer, 5 load timeout (low TMO_W bits), 6 status, 7 last run cycles. Registers 1 to 5 read back what was written while idle. Writes to them while busy are ignored.
- R3: A start write while idle sets busy on the next cycle and raises cfg_req, carrying the context base and count. arr_run is not asserted before cfg_ack has been seen during cfg_req.
- R4: After cfg_ack, arr_run is held, carrying the source and destination pointers, until run_done. wb_req then rises, carrying the destination pointer.
- R5: irq and status bit 1 (done) rise only after wb_ack completes the write-back, or after a load timeout.
- R6: At most one of cfg_req, arr_run and wb_req is high at any time. irq is never high while busy (status bit 0) is high.
- R7: irq is level-sensitive and stays high until a status write with bit 1 set. That write also clears status bits 2 and 3.
- R8: A start write while busy is ignored: the running job continues unchanged, no second job is launched, and sticky status bit 2 is set.
- R9: If cfg_ack does not arrive within the programmed timeout T cycles of load (T of 0 acts as 1), the job aborts: arr_run and wb_req are never raised, status bit 3 is set, and done/irq rise.
- R10: Register 7 reports the number of clock cycles arr_run was high in the last job. It is cleared when a new job starts loading, so an aborted job reports 0.
- R11: An accepted start clears a pending done/irq on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (write and read) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| busy | output | 1 | A job is in flight; the processor must stay idle |
| done | output | 1 | Sticky job-finished flag |
| irq | output | 1 | Level completion interrupt |
| cfg_req | output | 1 | Request to configuration loader |
| cfg_base | output | DATA_W | Context base for the loader |
| cfg_count | output | DATA_W | Context count for the loader |
| cfg_ack | input | 1 | Loader finished |
| arr_run | output | 1 | Array may execute the kernel |
| arr_src | output | DATA_W | Source data pointer |
| arr_dst | output | DATA_W | Destination data pointer |
| run_done | input | 1 | Array finished the kernel |
| wb_req | output | 1 | Request to write results to shared memory |
| wb_dst | output | DATA_W | Write-back destination pointer |
| wb_ack | input | 1 | Write-back complete |

## Verification
A sequencer stuck in or skipping a stage shows at the handshake pins within one cycle. Two requests are high together, arr_run rises without a preceding acknowledge, or irq rises before write-back has been acknowledged. The scoreboard holds the expected order of request edges and their payloads, so a reordered, repeated or missing stage is reported at the first edge that differs. A wrong timeout count or run counter shows in the status and cycle registers as soon as the job ends. A done flag that clears or persists wrongly is caught by reading the status register and watching irq across idle cycles.

// File: rtl/acc_host_pkg.sv
package acc_host_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_LOAD = 3'd1,
        SEQ_RUN  = 3'd2,
        SEQ_WB   = 3'd3,
        SEQ_DONE = 3'd4
    } seq_state_e;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_CBASE = 3'd1;
    localparam logic [REG_AW-1:0] RA_CCNT  = 3'd2;
    localparam logic [REG_AW-1:0] RA_SRC   = 3'd3;
    localparam logic [REG_AW-1:0] RA_DST   = 3'd4;
    localparam logic [REG_AW-1:0] RA_TMO   = 3'd5;
    localparam logic [REG_AW-1:0] RA_STAT  = 3'd6;
    localparam logic [REG_AW-1:0] RA_CYC   = 3'd7;

    localparam int unsigned SB_BUSY = 0;
    localparam int unsigned SB_DONE = 1;
    localparam int unsigned SB_EBSY = 2;
    localparam int unsigned SB_ETMO = 3;

    typedef struct packed {
        logic go;
        logic reject;
        logic clear;
    } bus_cmd_t;

    typedef struct packed {
        logic finish;
        logic abort;
    } seq_evt_t;

    function automatic logic in_flight(seq_state_e s);
        return s != SEQ_IDLE;
    endfunction

endpackage

// File: rtl/acc_host_regs.sv
module acc_host_regs
    import acc_host_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TMO_W  = 16,
    parameter int unsigned CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  seq_evt_t          evt,
    input  logic [CYC_W-1:0]  cycles,
    output bus_cmd_t          cmd,
    output logic [DATA_W-1:0] ctx_base,
    output logic [DATA_W-1:0] ctx_cnt,
    output logic [DATA_W-1:0] src_ptr,
    output logic [DATA_W-1:0] dst_ptr,
    output logic [TMO_W-1:0]  tmo_lim,
    output logic              done_q,
    output logic              ebsy_q,
    output logic              etmo_q
);

    logic wr_ctrl;
    logic wr_cfg;

    always_comb begin
        wr_ctrl    = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0];
        wr_cfg     = reg_we && !busy;
        cmd.go     = wr_ctrl && !busy;
        cmd.reject = wr_ctrl && busy;
        cmd.clear  = reg_we && (reg_addr == RA_STAT) && reg_wdata[SB_DONE];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_base <= '0;
            ctx_cnt  <= '0;
            src_ptr  <= '0;
            dst_ptr  <= '0;
            tmo_lim  <= '0;
        end else if (wr_cfg) begin
            case (reg_addr)
                RA_CBASE: ctx_base <= reg_wdata;
                RA_CCNT:  ctx_cnt  <= reg_wdata;
                RA_SRC:   src_ptr  <= reg_wdata;
                RA_DST:   dst_ptr  <= reg_wdata;
                RA_TMO:   tmo_lim  <= reg_wdata[TMO_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ebsy_q <= 1'b0;
            etmo_q <= 1'b0;
        end else begin
            if (evt.finish)
                done_q <= 1'b1;
            else if (cmd.go || cmd.clear)
                done_q <= 1'b0;

            if (cmd.reject)
                ebsy_q <= 1'b1;
            else if (cmd.clear)
                ebsy_q <= 1'b0;

            if (evt.abort)
                etmo_q <= 1'b1;
            else if (cmd.clear)
                etmo_q <= 1'b0;
        end
    end

    logic [3:0] stat_bits;

    always_comb begin
        stat_bits          = '0;
        stat_bits[SB_BUSY] = busy;
        stat_bits[SB_DONE] = done_q;
        stat_bits[SB_EBSY] = ebsy_q;
        stat_bits[SB_ETMO] = etmo_q;
        case (reg_addr)
            RA_CBASE: reg_rdata = ctx_base;
            RA_CCNT:  reg_rdata = ctx_cnt;
            RA_SRC:   reg_rdata = src_ptr;
            RA_DST:   reg_rdata = dst_ptr;
            RA_TMO:   reg_rdata = DATA_W'(tmo_lim);
            RA_STAT:  reg_rdata = DATA_W'(stat_bits);
            RA_CYC:   reg_rdata = DATA_W'(cycles);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/acc_host_seq.sv
module acc_host_seq
    import acc_host_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             cfg_ack,
    input  logic             run_done,
    input  logic             wb_ack,
    input  logic [TMO_W-1:0] tmo_lim,
    output seq_state_e       state,
    output seq_evt_t         evt
);

    localparam int unsigned CMP_W = TMO_W + 1;

    seq_state_e       nxt;
    logic [TMO_W-1:0] wait_cnt;
    logic             expired;

    always_comb begin
        expired = (CMP_W'(wait_cnt) + CMP_W'(1)) >= CMP_W'(tmo_lim);
    end

    always_comb begin
        nxt       = state;
        evt.abort = 1'b0;
        case (state)
            SEQ_IDLE: if (go) nxt = SEQ_LOAD;
            SEQ_LOAD: begin
                if (cfg_ack) begin
                    nxt = SEQ_RUN;
                end else if (expired) begin
                    nxt       = SEQ_DONE;
                    evt.abort = 1'b1;
                end
            end
            SEQ_RUN:  if (run_done) nxt = SEQ_WB;
            SEQ_WB:   if (wb_ack) nxt = SEQ_DONE;
            SEQ_DONE: nxt = SEQ_IDLE;
            default:  nxt = SEQ_IDLE;
        endcase
        evt.finish = (state == SEQ_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            wait_cnt <= '0;
        end else begin
            state    <= nxt;
            wait_cnt <= (state == SEQ_LOAD) ? wait_cnt + TMO_W'(1) : '0;
        end
    end

endmodule

// File: rtl/acc_host_perf.sv
module acc_host_perf
    import acc_host_pkg::*;
#(
    parameter int unsigned CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_e       state,
    output logic [CYC_W-1:0] cycles
);

    localparam logic [CYC_W-1:0] CYC_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            cycles <= '0;
        else if (state == SEQ_LOAD)
            cycles <= '0;
        else if (state == SEQ_RUN && cycles != CYC_MAX)
            cycles <= cycles + CYC_W'(1);
    end

endmodule

// File: rtl/acc_host_ctrl.sv
module acc_host_ctrl
    import acc_host_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TMO_W  = 16,
    parameter int unsigned CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              busy,
    output logic              done,
    output logic              irq,
    output logic              cfg_req,
    output logic [DATA_W-1:0] cfg_base,
    output logic [DATA_W-1:0] cfg_count,
    input  logic              cfg_ack,
    output logic              arr_run,
    output logic [DATA_W-1:0] arr_src,
    output logic [DATA_W-1:0] arr_dst,
    input  logic              run_done,
    output logic              wb_req,
    output logic [DATA_W-1:0] wb_dst,
    input  logic              wb_ack
);

    seq_state_e       state;
    seq_evt_t         evt;
    bus_cmd_t         cmd;
    logic [CYC_W-1:0] cycles;
    logic [TMO_W-1:0] tmo_lim;
    logic [DATA_W-1:0] src_ptr;
    logic [DATA_W-1:0] dst_ptr;
    logic             done_q;
    logic             ebsy_q;
    logic             etmo_q;

    assign busy = in_flight(state);

    acc_host_regs #(.DATA_W(DATA_W), .TMO_W(TMO_W), .CYC_W(CYC_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .evt       (evt),
        .cycles    (cycles),
        .cmd       (cmd),
        .ctx_base  (cfg_base),
        .ctx_cnt   (cfg_count),
        .src_ptr   (src_ptr),
        .dst_ptr   (dst_ptr),
        .tmo_lim   (tmo_lim),
        .done_q    (done_q),
        .ebsy_q    (ebsy_q),
        .etmo_q    (etmo_q)
    );

    acc_host_seq #(.TMO_W(TMO_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (cmd.go),
        .cfg_ack  (cfg_ack),
        .run_done (run_done),
        .wb_ack   (wb_ack),
        .tmo_lim  (tmo_lim),
        .state    (state),
        .evt      (evt)
    );

    acc_host_perf #(.CYC_W(CYC_W)) u_perf (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .cycles (cycles)
    );

    always_comb begin
        done    = done_q;
        irq     = done_q;
        cfg_req = (state == SEQ_LOAD);
        arr_run = (state == SEQ_RUN);
        wb_req  = (state == SEQ_WB);
        arr_src = src_ptr;
        arr_dst = dst_ptr;
        wb_dst  = dst_ptr;
    end

endmodule

// File: rtl/acc_host_ctrl_chk.sv
module acc_host_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic reg_we,
    input logic busy,
    input logic irq,
    input logic cfg_req,
    input logic cfg_ack,
    input logic arr_run,
    input logic run_done,
    input logic wb_req,
    input logic wb_ack,
    input logic etmo_q
);

    AST_RUN_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(arr_run) |-> ($past(cfg_req) && $past(cfg_ack))); // R3

    AST_WB_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_req) |-> ($past(arr_run) && $past(run_done))); // R4

    AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (etmo_q || $past(wb_ack, 2))); // R5

    AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_req, arr_run, wb_req})); // R6

    AST_NO_IRQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq); // R6

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (irq && !reg_we) |=> irq); // R7

endmodule

bind acc_host_ctrl acc_host_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .busy     (busy),
    .irq      (irq),
    .cfg_req  (cfg_req),
    .cfg_ack  (cfg_ack),
    .arr_run  (arr_run),
    .run_done (run_done),
    .wb_req   (wb_req),
    .wb_ack   (wb_ack),
    .etmo_q   (etmo_q)
);

// File: tb/acc_host_ctrl_bench.sv
module acc_host_ctrl_bench;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic busy, done, irq, cfg_req, arr_run, wb_req;
    logic [DW-1:0] cfg_base, cfg_count, arr_src, arr_dst, wb_dst;
    logic cfg_ack = 1'b0, run_done = 1'b0, wb_ack = 1'b0;

    always #10 clk = ~clk;

    acc_host_ctrl u_acc_host_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .done(done), .irq(irq), .cfg_req(cfg_req), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .cfg_ack(cfg_ack), .arr_run(arr_run),
        .arr_src(arr_src), .arr_dst(arr_dst), .run_done(run_done),
        .wb_req(wb_req), .wb_dst(wb_dst), .wb_ack(wb_ack)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        int            kind;   // 1 load, 2 run, 3 writeback, 4 irq
        logic [DW-1:0] val;
        logic [DW-1:0] val2;
    } exp_t;
    exp_t exp_q[$];

    int cfg_delay = 0;
    bit cfg_never = 1'b0;
    int run_len   = 1;
    int wb_delay  = 0;
    int run_rises = 0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Loader, array and memory models
    int cc = 0, rc = 0, wc = 0;
    always @(negedge clk) begin
        if (cfg_req && !cfg_never) begin
            cfg_ack = (cc == cfg_delay);
            cc++;
        end else begin
            cfg_ack = 1'b0; cc = 0;
        end
        if (arr_run) begin
            run_done = (rc == run_len - 1);
            rc++;
        end else begin
            run_done = 1'b0; rc = 0;
        end
        if (wb_req) begin
            wb_ack = (wc == wb_delay);
            wc++;
        end else begin
            wb_ack = 1'b0; wc = 0;
        end
    end

    // Monitor: pops expected handshake edges in order
    logic p_cfg = 0, p_run = 0, p_wb = 0, p_irq = 0;
    task automatic pop_cmp(input int kind, input logic [DW-1:0] v, input logic [DW-1:0] v2, input string req);
        exp_t e;
        if (exp_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("[TB] FAIL %s unexpected event actual=%0d expected=none", req, kind);
        end else begin
            e = exp_q.pop_front();
            check({req, " order"}, DW'(kind), DW'(e.kind));
            if (kind == e.kind) begin
                check({req, " payload"}, v, e.val);
                check({req, " payload2"}, v2, e.val2);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_req && !p_cfg) begin
                pop_cmp(1, cfg_base, cfg_count, "R3 load");
                check("R3 no run during load", DW'(arr_run), 0);
            end
            if (arr_run && !p_run) begin
                run_rises++;
                pop_cmp(2, arr_src, arr_dst, "R4 run");
            end
            if (wb_req && !p_wb) pop_cmp(3, wb_dst, 0, "R4 writeback");
            if (irq && !p_irq) pop_cmp(4, 0, 0, "R5 irq");
        end
        p_cfg = cfg_req; p_run = arr_run; p_wb = wb_req; p_irq = irq;
    end

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup_job(input logic [DW-1:0] b, input logic [DW-1:0] c,
                             input logic [DW-1:0] s, input logic [DW-1:0] d,
                             input bit aborts);
        exp_t e;
        wr(3'd1, b); wr(3'd2, c); wr(3'd3, s); wr(3'd4, d);
        e.kind = 1; e.val = b; e.val2 = c; exp_q.push_back(e);
        if (!aborts) begin
            e.kind = 2; e.val = s; e.val2 = d; exp_q.push_back(e);
            e.kind = 3; e.val = d; e.val2 = 0; exp_q.push_back(e);
        end
        e.kind = 4; e.val = 0; e.val2 = 0; exp_q.push_back(e);
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
        @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_tests++; n_fail++;
            $display("[TB] FAIL watchdog actual=%0d expected<20000", wd);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", DW'(busy), 0);
        check("R1 irq", DW'(irq), 0);
        check("R1 req lines", DW'({cfg_req, arr_run, wb_req, done}), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            check("R1 register zero", r, 0);
        end

        // R2 readback while idle
        wr(3'd5, 32'd50);
        rd(3'd5, r); check("R2 timeout readback", r, 32'd50);
        wr(3'd3, 32'hA5A5_0001);
        rd(3'd3, r); check("R2 source readback", r, 32'hA5A5_0001);

        // Job A: normal launch, busy writes probed
        cfg_delay = 2; run_len = 4; wb_delay = 1;
        setup_job(32'h100, 32'd3, 32'h2000, 32'h3000, 1'b0);
        wr(3'd0, 32'h1);
        check("R6 busy after start", DW'(busy), 1);
        rd(3'd6, r); check("R6 status busy bit0", r & 32'h1, 1);
        wr(3'd1, 32'hDEAD);     // ignored while busy (R2)
        wr(3'd0, 32'h1);        // rejected start (R8)
        wait_irq();
        check("R5 done bit1", DW'(done), 1);
        check("R6 idle at irq", DW'(busy), 0);
        rd(3'd1, r); check("R2 write while busy ignored", r, 32'h100);
        rd(3'd6, r); check("R8 sticky busy error bit2", r, 32'h6);
        check("R8 single run", DW'(run_rises), 1);
        rd(3'd7, r); check("R10 run cycles job A", r, 32'd4);

        // R7 level hold and clear
        repeat (10) @(negedge clk);
        check("R7 irq held", DW'(irq), 1);
        wr(3'd6, 32'h2);
        check("R7 irq cleared", DW'(irq), 0);
        rd(3'd6, r); check("R7 status cleared", r, 0);

        // Job B: immediate ack, one-cycle run
        cfg_delay = 0; run_len = 1; wb_delay = 0;
        setup_job(32'h40, 32'd1, 32'h11, 32'h22, 1'b0);
        wr(3'd0, 32'h1);
        wait_irq();
        rd(3'd7, r); check("R10 run cycles job B", r, 32'd1);

        // Job C started with irq pending
        run_len = 7;
        setup_job(32'h77, 32'd9, 32'h33, 32'h44, 1'b0);
        check("R11 irq pending before start", DW'(irq), 1);
        wr(3'd0, 32'h1);
        check("R11 irq cleared by start", DW'(irq), 0);
        wait_irq();
        rd(3'd7, r); check("R10 run cycles job C", r, 32'd7);
        wr(3'd6, 32'h2);

        // Job D: load timeout
        cfg_never = 1'b1;
        wr(3'd5, 32'd5);
        setup_job(32'h500, 32'd2, 32'h55, 32'h66, 1'b1);
        run_rises = 0;
        wr(3'd0, 32'h1);
        wait_irq();
        rd(3'd6, r); check("R9 timeout status", r, 32'hA);
        check("R9 no run after abort", DW'(run_rises), 0);
        check("R9 load dropped", DW'({cfg_req, arr_run, wb_req}), 0);
        rd(3'd7, r); check("R10 aborted job cycles", r, 0);
        wr(3'd6, 32'h2);
        cfg_never = 1'b0;

        repeat (3) @(negedge clk);
        check("R5 all expected events seen", DW'(exp_q.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule